// File: doc/BRIEF.md
# Windowed Command and Status Unit

This block is the control core that sits behind a network adapter's host register file. The host sees one 16-bit location. A write to it is taken as a command: a 5-bit opcode in the top bits and an 11-bit argument below. A read returns a status word assembled from latched event bits, live busy indications and the number of the register window that is currently selected. The commands select the window, switch the receive and transmit paths on and off, reset either path, discard the current receive packet, program the receive address filter, acknowledge events and load two separate masks. One mask picks which status bits the host can see. The other picks which of them raise the interrupt.

The datapath around the block is represented only by its event pulses and a DMA busy level. The block returns per-path enables, the filter class bits, one-cycle reset and discard strobes, the selected window and an interrupt line. The reset and discard commands hold a command-in-progress flag for a fixed number of cycles. Host software polls that flag until it drops.

The host reset input is asynchronous and active low. Its release is synchronised over two clock edges inside the block, and commands issued during those edges are ignored.

Top module: `cmd_status_unit`

## Requirements
- R1: After reset the status word reads 0x0000, the interrupt is low, both path enables are low, the filter is 0, the window is 0 and no strobe is active.
- R2: Opcode 1 loads the selected window from argument bits 2:0. The window appears on `win_sel` and in status bits 15:13 from the cycle after the write.
- R3: Opcode 4 turns the receive enable on and opcode 3 turns it off. Opcode 9 turns the transmit enable on and opcode 10 turns it off. Each change takes effect in the cycle after the write.
- R4: Opcode 5 produces a one-cycle `rx_reset_pulse` and clears the receive enable. Opcode 11 does the same with `tx_reset_pulse` and the transmit enable.
- R5: Opcodes 0, 5, 8 and 11 set status bit 12 (command in progress) for exactly BUSY_CYCLES cycles, starting the cycle after the write. A second such command reloads the full count.
- R6: Opcode 8 produces a one-cycle `rx_discard_pulse` and leaves the path enables unchanged.
- R7: A pulse on `evt_pulse[i]`, for i from 0 to 10, sets latched status bit i in the next cycle. The bit stays set until it is cleared.
- R8: Opcode 13 clears every latched bit whose argument bit is 1. If an event pulse arrives in the same cycle for the same bit, the bit stays set.
- R9: Opcode 15 loads the visibility mask. Status bits 10:0 read as the latched bits ANDed with that mask. Bit 11 always shows the `dma_busy` input and bit 12 always shows command in progress.
- R10: Opcode 14 loads the interrupt mask. `irq` is high exactly when some latched bit is also set in that mask. The visibility mask has no effect on `irq`.
- R11: Opcode 16 loads `rx_filter` from argument bits 3:0, where 1 means station, 2 multicast, 4 broadcast and 8 promiscuous.
- R12: Opcode 0 clears the window, both enables, the filter, both masks and all latched bits. It pulses both path reset strobes and starts command in progress.
- R13: Opcodes 2, 6, 7, 12 and 17 to 31 change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe to the command location |
| cmd_word | input | 16 | Command: opcode in bits 15:11, argument in bits 10:0 |
| evt_pulse | input | 11 | Datapath event pulses, one per latched status bit |
| dma_busy | input | 1 | Live DMA activity level |
| status_word | output | 16 | Status read value |
| irq | output | 1 | Interrupt request |
| win_sel | output | 3 | Selected register window |
| rx_enable | output | 1 | Receive path enable |
| tx_enable | output | 1 | Transmit path enable |
| rx_filter | output | 4 | Receive address class enables |
| rx_reset_pulse | output | 1 | One-cycle receive path reset |
| tx_reset_pulse | output | 1 | One-cycle transmit path reset |
| rx_discard_pulse | output | 1 | One-cycle discard of the current receive packet |

## Verification
The bench builds the unit with BUSY_CYCLES set to 5. With that value the busy window is short enough that the bench can count it out exactly. It is also long enough that a second reset command can land while the flag is still up, which puts the reload case within reach. Event pulses and acknowledges are driven both on their own and in the same cycle on the same bit. Together with a partial visibility mask and a held `dma_busy`, this separates what the host can see from what can interrupt.

// File: rtl/cmd_status_pkg.sv
package cmd_status_pkg;
  localparam int WORD_W  = 16;
  localparam int OP_W    = 5;
  localparam int ARG_W   = WORD_W - OP_W;
  localparam int WIN_W   = 3;
  localparam int LATCH_W = 11;
  localparam int FILT_W  = 4;
  localparam int ST_DMA  = LATCH_W;
  localparam int ST_BUSY = LATCH_W + 1;

  typedef enum logic [OP_W-1:0] {
    OP_TOTAL_RST  = 5'd0,
    OP_WINDOW     = 5'd1,
    OP_RX_OFF     = 5'd3,
    OP_RX_ON      = 5'd4,
    OP_RX_RST     = 5'd5,
    OP_RX_DISCARD = 5'd8,
    OP_TX_ON      = 5'd9,
    OP_TX_OFF     = 5'd10,
    OP_TX_RST     = 5'd11,
    OP_ACK        = 5'd13,
    OP_INT_MASK   = 5'd14,
    OP_VIS_MASK   = 5'd15,
    OP_FILTER     = 5'd16
  } opcode_e;

  typedef struct packed {
    logic total_rst;
    logic win_ld;
    logic rx_off;
    logic rx_on;
    logic rx_rst;
    logic rx_discard;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic ack;
    logic int_ld;
    logic vis_ld;
    logic filt_ld;
  } cmd_dec_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_status_pkg::*;
(
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  output cmd_dec_t          dec_o,
  output logic [ARG_W-1:0]  arg_o
);
  logic [OP_W-1:0] op;

  assign op    = word_i[WORD_W-1:ARG_W];
  assign arg_o = word_i[ARG_W-1:0];

  always_comb begin
    dec_o = '0;
    if (wr_i) begin
      case (op)
        OP_TOTAL_RST:  dec_o.total_rst  = 1'b1;
        OP_WINDOW:     dec_o.win_ld     = 1'b1;
        OP_RX_OFF:     dec_o.rx_off     = 1'b1;
        OP_RX_ON:      dec_o.rx_on      = 1'b1;
        OP_RX_RST:     dec_o.rx_rst     = 1'b1;
        OP_RX_DISCARD: dec_o.rx_discard = 1'b1;
        OP_TX_ON:      dec_o.tx_on      = 1'b1;
        OP_TX_OFF:     dec_o.tx_off     = 1'b1;
        OP_TX_RST:     dec_o.tx_rst     = 1'b1;
        OP_ACK:        dec_o.ack        = 1'b1;
        OP_INT_MASK:   dec_o.int_ld     = 1'b1;
        OP_VIS_MASK:   dec_o.vis_ld     = 1'b1;
        OP_FILTER:     dec_o.filt_ld    = 1'b1;
        default:       dec_o            = '0;
      endcase
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = start_i || (cnt_q != '0);
    if (start_i)             cnt_d = CNT_W'(CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CYCLES));
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !$past(start_i));
endmodule

// File: rtl/event_latch.sv
module event_latch
  import cmd_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LATCH_W-1:0] set_i,
  input  logic               clr_all_i,
  input  logic               ack_i,
  input  logic [LATCH_W-1:0] ack_mask_i,
  output logic [LATCH_W-1:0] lat_o
);
  logic [LATCH_W-1:0] lat_q, lat_en;

  for (genvar i = 0; i < LATCH_W; i++) begin : g_bit
    assign lat_en[i] = set_i[i] || clr_all_i || (ack_i && ack_mask_i[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lat_q[i] <= 1'b0;
      else if (lat_en[i]) lat_q[i] <= set_i[i];
    end
  end

  assign lat_o = lat_q;

  assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((lat_o & $past(set_i)) == $past(set_i)));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ((lat_o & $past(ack_mask_i & ~set_i)) == '0));
endmodule

// File: rtl/cmd_status_unit.sv
module cmd_status_unit
  import cmd_status_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [15:0]        cmd_word,
  input  logic [10:0]        evt_pulse,
  input  logic               dma_busy,
  output logic [15:0]        status_word,
  output logic               irq,
  output logic [2:0]         win_sel,
  output logic               rx_enable,
  output logic               tx_enable,
  output logic [3:0]         rx_filter,
  output logic               rx_reset_pulse,
  output logic               tx_reset_pulse,
  output logic               rx_discard_pulse
);
  typedef struct packed {
    logic [WIN_W-1:0]   win;
    logic               rx_en;
    logic               tx_en;
    logic [FILT_W-1:0]  filt;
    logic [LATCH_W-1:0] int_mask;
    logic [LATCH_W-1:0] vis_mask;
    logic               rx_p;
    logic               tx_p;
    logic               disc_p;
  } ctl_t;

  logic [1:0]         rst_pipe;
  logic               rst_q;
  cmd_dec_t           dec;
  logic [ARG_W-1:0]   arg;
  ctl_t               ctl_q, ctl_d;
  logic               ctl_en;
  logic               busy_start, busy;
  logic [LATCH_W-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  cmd_decode u_dec (
    .wr_i   (cmd_wr),
    .word_i (cmd_word),
    .dec_o  (dec),
    .arg_o  (arg)
  );

  assign busy_start = dec.total_rst | dec.rx_rst | dec.tx_rst | dec.rx_discard;

  busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst_n   (rst_q),
    .start_i (busy_start),
    .busy_o  (busy)
  );

  event_latch u_lat (
    .clk        (clk),
    .rst_n      (rst_q),
    .set_i      (evt_pulse),
    .clr_all_i  (dec.total_rst),
    .ack_i      (dec.ack),
    .ack_mask_i (arg),
    .lat_o      (lat)
  );

  always_comb begin
    ctl_d        = ctl_q;
    ctl_d.rx_p   = 1'b0;
    ctl_d.tx_p   = 1'b0;
    ctl_d.disc_p = 1'b0;
    ctl_en       = cmd_wr | ctl_q.rx_p | ctl_q.tx_p | ctl_q.disc_p;
    if (dec.total_rst) begin
      ctl_d      = '0;
      ctl_d.rx_p = 1'b1;
      ctl_d.tx_p = 1'b1;
    end
    if (dec.win_ld)     ctl_d.win      = arg[WIN_W-1:0];
    if (dec.rx_off)     ctl_d.rx_en    = 1'b0;
    if (dec.rx_on)      ctl_d.rx_en    = 1'b1;
    if (dec.rx_rst) begin
      ctl_d.rx_en = 1'b0;
      ctl_d.rx_p  = 1'b1;
    end
    if (dec.rx_discard) ctl_d.disc_p   = 1'b1;
    if (dec.tx_on)      ctl_d.tx_en    = 1'b1;
    if (dec.tx_off)     ctl_d.tx_en    = 1'b0;
    if (dec.tx_rst) begin
      ctl_d.tx_en = 1'b0;
      ctl_d.tx_p  = 1'b1;
    end
    if (dec.int_ld)     ctl_d.int_mask = arg;
    if (dec.vis_ld)     ctl_d.vis_mask = arg;
    if (dec.filt_ld)    ctl_d.filt     = arg[FILT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign status_word      = {ctl_q.win, busy, dma_busy, lat & ctl_q.vis_mask};
  assign irq              = |(lat & ctl_q.int_mask);
  assign win_sel          = ctl_q.win;
  assign rx_enable        = ctl_q.rx_en;
  assign tx_enable        = ctl_q.tx_en;
  assign rx_filter        = ctl_q.filt;
  assign rx_reset_pulse   = ctl_q.rx_p;
  assign tx_reset_pulse   = ctl_q.tx_p;
  assign rx_discard_pulse = ctl_q.disc_p;

  assert_win_load_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_wr && cmd_word[15:11] == 5'd1) |=> (win_sel == $past(cmd_word[2:0])));
  assert_rxrst_off_R4: assert property (@(posedge clk) disable iff (!rst_q)
    rx_reset_pulse |-> !rx_enable);
  assert_txrst_off_R4: assert property (@(posedge clk) disable iff (!rst_q)
    tx_reset_pulse |-> !tx_enable);
  assert_unused_op_R13: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_wr && cmd_word[15:11] == 5'd2) |=>
      ($stable(win_sel) && $stable(rx_enable) && $stable(tx_enable) && $stable(rx_filter)));
endmodule

// File: tb/test_cmd_status_unit.sv
module test_cmd_status_unit;
  localparam int CLK_P = 10;
  localparam int BC    = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [10:0] evt_pulse = '0;
  logic        dma_busy = 1'b0;
  logic [15:0] status_word;
  logic        irq, rx_enable, tx_enable;
  logic [2:0]  win_sel;
  logic [3:0]  rx_filter;
  logic        rx_reset_pulse, tx_reset_pulse, rx_discard_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cmd_status_unit #(.BUSY_CYCLES(BC)) i_cmd_status_unit (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .evt_pulse(evt_pulse), .dma_busy(dma_busy), .status_word(status_word),
    .irq(irq), .win_sel(win_sel), .rx_enable(rx_enable), .tx_enable(tx_enable),
    .rx_filter(rx_filter), .rx_reset_pulse(rx_reset_pulse),
    .tx_reset_pulse(tx_reset_pulse), .rx_discard_pulse(rx_discard_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference model
  int m_win, m_rx, m_tx, m_filt, m_im, m_vm, m_lat, m_busy, m_rxp, m_txp, m_dp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0; m_im = 0; m_vm = 0;
      m_lat = 0; m_busy = 0; m_rxp = 0; m_txp = 0; m_dp = 0;
    end else begin
      int op, arg, nl;
      bit st;
      op = int'(cmd_word[15:11]); arg = int'(cmd_word[10:0]);
      m_rxp = 0; m_txp = 0; m_dp = 0; st = 0; nl = m_lat;
      if (cmd_wr) begin
        case (op)
          0: begin m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0; m_im = 0; m_vm = 0;
                   nl = 0; m_rxp = 1; m_txp = 1; st = 1; end
          1: m_win = arg % 8;
          3: m_rx = 0;
          4: m_rx = 1;
          5: begin m_rx = 0; m_rxp = 1; st = 1; end
          8: begin m_dp = 1; st = 1; end
          9: m_tx = 1;
          10: m_tx = 0;
          11: begin m_tx = 0; m_txp = 1; st = 1; end
          13: nl = m_lat & ~arg & 'h7FF;
          14: m_im = arg;
          15: m_vm = arg;
          16: m_filt = arg % 16;
          default: ;
        endcase
      end
      m_lat = nl | int'(evt_pulse);
      if (st) m_busy = BC;
      else if (m_busy > 0) m_busy = m_busy - 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      int exp_st;
      exp_st = (m_win << 13) | ((m_busy != 0) << 12) | (int'(dma_busy) << 11) | (m_lat & m_vm);
      chk("R9 status", int'(status_word), exp_st);
      chk("R10 irq", int'(irq), int'((m_lat & m_im) != 0));
      chk("R2 window", int'(win_sel), m_win);
      chk("R3 rx_enable", int'(rx_enable), m_rx);
      chk("R3 tx_enable", int'(tx_enable), m_tx);
      chk("R11 filter", int'(rx_filter), m_filt);
      chk("R4 rx_reset", int'(rx_reset_pulse), m_rxp);
      chk("R4 tx_reset", int'(tx_reset_pulse), m_txp);
      chk("R6 discard", int'(rx_discard_pulse), m_dp);
    end
  end

  task automatic cmd(input int op, input int arg);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = {op[4:0], arg[10:0]};
    @(negedge clk);
    cmd_wr = 1'b0; cmd_word = '0;
  endtask

  task automatic evt(input int mask);
    @(negedge clk);
    evt_pulse = mask[10:0];
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic ack_with_evt(input int ackm, input int ev);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = {5'd13, ackm[10:0]}; evt_pulse = ev[10:0];
    @(negedge clk);
    cmd_wr = 1'b0; cmd_word = '0; evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic count_busy(input string tag);
    int n;
    n = 0;
    #1;
    while (status_word[12] && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk(tag, n, BC);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    #1;
    // R1: reset state
    chk("R1 status", int'(status_word), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 enables", int'({rx_enable, tx_enable}), 0);
    chk("R1 filter/window", int'({rx_filter, win_sel}), 0);

    // R9 visibility all, R2 window
    cmd(15, 'h7FF);
    cmd(1, 5);
    #1;
    chk("R2 win_sel", int'(win_sel), 5);
    chk("R2 status window", int'(status_word[15:13]), 5);

    // R3 enables
    cmd(4, 0); cmd(9, 0);
    #1;
    chk("R3 both on", int'({rx_enable, tx_enable}), 3);
    cmd(3, 0);
    #1;
    chk("R3 rx off", int'({rx_enable, tx_enable}), 1);

    // R11 filter
    cmd(16, 'h7FA);
    #1;
    chk("R11 filter", int'(rx_filter), 'hA);

    // R7 event latching, R10 interrupt mask
    evt('h014);
    idle(2);
    #1;
    chk("R7 latched", int'(status_word[10:0]), 'h014);
    chk("R10 masked off", int'(irq), 0);
    cmd(14, 'h010);
    #1;
    chk("R10 irq on", int'(irq), 1);

    // R8 acknowledge, and event winning over ack
    cmd(13, 'h010);
    #1;
    chk("R8 ack irq", int'(irq), 0);
    chk("R8 ack status", int'(status_word[10:0]), 'h004);
    ack_with_evt('h004, 'h004);
    #1;
    chk("R8 event wins", int'(status_word[10:0]), 'h004);

    // R9 partial visibility, dma bit always shown
    cmd(14, 'h004);
    cmd(15, 'h001);
    dma_busy = 1'b1;
    idle(1);
    #1;
    chk("R9 hidden bit", int'(status_word[10:0]), 0);
    chk("R10 hidden still irq", int'(irq), 1);
    chk("R9 dma bit", int'(status_word[11]), 1);
    dma_busy = 1'b0;
    cmd(15, 'h7FF);

    // R4 transmit reset and R5 busy length
    cmd(11, 0);
    #1;
    chk("R4 tx pulse", int'(tx_reset_pulse), 1);
    chk("R4 tx off", int'(tx_enable), 0);
    count_busy("R5 busy length tx reset");

    // R4 receive reset
    cmd(4, 0);
    cmd(5, 0);
    #1;
    chk("R4 rx pulse", int'(rx_reset_pulse), 1);
    chk("R4 rx off", int'(rx_enable), 0);
    idle(2);
    // R5 reload
    cmd(5, 0);
    count_busy("R5 busy reload");

    // R6 discard
    cmd(4, 0);
    cmd(8, 0);
    #1;
    chk("R6 discard pulse", int'(rx_discard_pulse), 1);
    chk("R6 rx kept", int'(rx_enable), 1);
    count_busy("R5 busy discard");

    // R13 unused opcodes
    cmd(2, 'h7FF); cmd(6, 'h7FF); cmd(7, 'h7FF); cmd(12, 'h7FF);
    cmd(17, 'h7FF); cmd(31, 'h7FF);
    idle(1);
    #1;
    chk("R13 window kept", int'(win_sel), 5);
    chk("R13 status kept", int'(status_word), (5 << 13) | 'h004);
    chk("R13 filter kept", int'(rx_filter), 'hA);

    // R12 total reset
    cmd(9, 0);
    cmd(0, 0);
    #1;
    chk("R12 busy", int'(status_word), 1 << 12);
    chk("R12 pulses", int'({rx_reset_pulse, tx_reset_pulse}), 3);
    chk("R12 cleared", int'({rx_enable, tx_enable, rx_filter, win_sel, irq}), 0);
    idle(BC + 1);
    evt('h7FF);
    idle(1);
    #1;
    chk("R12 masks cleared", int'({status_word, irq}), 0);

    idle(2);
    summary();
  end
endmodule